// File: doc/BRIEF.md
# Fixed-Priority Bus Ownership Arbiter

This block decides which of four bus masters owns a shared bus. Each master asks for the bus on its own active-low request line. The arbiter answers on four active-low grant lines and asserts at most one of them. Priority is fixed by index and never rotates. Master 0 always wins over master 1, master 1 over master 2, and so on.

The master that owns the bus may drive an active-low lock line while it uses the bus. While the lock is active, no master receives a fresh grant. If a more important master asks for the bus during a locked transfer, the current owner's grant is withdrawn at once so that it can finish up. The waiting master's grant is held back until the lock is released. Every change to a grant is registered on the rising clock edge. A clock with no grant always separates two different owners.

Top module: `fixed_prio_arb`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, all grant lines are high (no owner).
- R2: When no grant is held and `lock_n` is high, the next rising edge grants the lowest-numbered master whose request is low (bit i of `req_n`/`gnt_n` belongs to master i, and master 0 has the highest priority).
- R3: At most one bit of `gnt_n` is low in any cycle.
- R4: When no grant is held and `lock_n` is low, no grant is issued on that edge, whatever the requests.
- R5: An owner keeps its grant while `lock_n` is low and no higher-priority request is present, even if its own request has gone high.
- R6: A request from a higher-priority master removes the current grant on the next edge, whether or not the lock is active.
- R7: A grant never passes directly from one master to another: at least one cycle with all grants high lies between two owners.
- R8: If the owner's request goes high while `lock_n` is high, its grant is removed on the next edge. The edge after that grants the highest remaining request, or no one if none is pending.
- R9: Requests from lower-priority masters have no effect on an owner that keeps its request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N_MASTERS (4) | Bus requests, active low, bit i = master i |
| lock_n | input | 1 | Bus in use by the owner, active low |
| gnt_n | output | N_MASTERS (4) | Bus grants, active low, at most one low |

## Verification
The properties take the requests and the lock to be synchronous to `clk` and free of unknown values at every rising edge. They also take these inputs to hold steady across the sampling edge. They do not assume that only the owner drives the lock. The arbiter must stay safe even when the lock is active with no owner, so the stimulus deliberately includes that case. The bench changes every input only on the falling edge. It draws the lock and each request from fixed-seed random values. Directed sequences cover preemption under lock, release and re-grant, and owner drop-out.

// File: rtl/arb_pkg.sv
// Shared types for the fixed-priority bus arbiter.
package arb_pkg;
    // Ownership state of the arbiter.
    typedef enum logic {
        ST_FREE  = 1'b0,  // no grant asserted
        ST_OWNED = 1'b1   // one master holds the grant
    } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: returns the lowest-numbered active request.
// Assumes active-high request bits; index 0 has the highest priority.
module arb_prio_pick #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the lowest priority up so the highest priority wins last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/arb_above_mask.sv
// Detects a pending request with higher priority than a given owner.
// Assumes active-high request bits and a valid owner index below N_MASTERS.
module arb_above_mask #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]     owner,
    output logic                 higher
);
    logic [N_MASTERS-1:0] above;

    // above[i] is set when any master numbered below i is requesting.
    assign above[0] = 1'b0;
    generate
        for (genvar i = 1; i < N_MASTERS; i++) begin : g_above
            assign above[i] = above[i-1] | req[i-1];
        end
    endgenerate

    // Select the flag that belongs to the current owner.
    assign higher = above[owner];
endmodule

// File: rtl/arb_ctrl.sv
// Ownership controller: holds, withdraws and issues the single grant.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 locked,
    input  logic                 pick_any,
    input  logic [IDX_W-1:0]     pick_idx,
    input  logic                 higher,
    output logic                 own_vld,
    output logic [IDX_W-1:0]     own_idx
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             own_req;

    // Owner's own request bit.
    assign own_req = req[idx_q];

    // Next-state decision for the grant.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_FREE: begin
                if (!locked && pick_any) begin
                    state_d = ST_OWNED;
                    idx_d   = pick_idx;
                end
            end
            ST_OWNED: begin
                if (higher) begin
                    state_d = ST_FREE;
                end else if (!locked && !own_req) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // Register ownership state and owner index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign own_vld = (state_q == ST_OWNED);
    assign own_idx = idx_q;
endmodule

// File: rtl/fixed_prio_arb.sv
// Top: four-master fixed-priority arbiter with bus lock, active-low pins.
// Assumes all inputs are synchronous to clk; grants are registered.
module fixed_prio_arb #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 lock_n,
    output logic [N_MASTERS-1:0] gnt_n
);
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    logic [N_MASTERS-1:0] req;
    logic                 locked;
    logic                 pick_any;
    logic [IDX_W-1:0]     pick_idx;
    logic                 higher;
    logic                 own_vld;
    logic [IDX_W-1:0]     own_idx;

    // Convert pin polarity to active-high internal signals.
    assign req    = ~req_n;
    assign locked = ~lock_n;

    arb_prio_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
        .req (req),
        .any (pick_any),
        .idx (pick_idx)
    );

    arb_above_mask #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_above (
        .req    (req),
        .owner  (own_idx),
        .higher (higher)
    );

    arb_ctrl #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .locked   (locked),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .higher   (higher),
        .own_vld  (own_vld),
        .own_idx  (own_idx)
    );

    // Decode the owner into one active-low grant line per master.
    generate
        for (genvar i = 0; i < N_MASTERS; i++) begin : g_gnt
            assign gnt_n[i] = !(own_vld && (own_idx == IDX_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/fixed_prio_arb_chk.sv
// Protocol checker for fixed_prio_arb, observing pins only.
// Assumes inputs are known and synchronous to clk.
module fixed_prio_arb_chk #(
    parameter int N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_n,
    input logic                 lock_n,
    input logic [N_MASTERS-1:0] gnt_n
);
    localparam logic [N_MASTERS-1:0] NONE = {N_MASTERS{1'b1}};

    logic [N_MASTERS-1:0] rq;
    logic [N_MASTERS-1:0] low_req;
    logic                 hi_req;

    assign rq      = ~req_n;
    assign low_req = rq & (~rq + 1'b1);

    // Flag a request with priority above the current grant holder.
    always_comb begin
        hi_req = 1'b0;
        for (int i = 0; i < N_MASTERS; i++) begin
            for (int j = 0; j < N_MASTERS; j++) begin
                if (!gnt_n[i] && j < i && rq[j]) hi_req = 1'b1;
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk)
        $countones(~gnt_n) <= 1); // R3

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> gnt_n == NONE); // R1

    AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n == NONE && !lock_n) |=> gnt_n == NONE); // R4

    AST_GRANT_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n == NONE && lock_n) |=> (~gnt_n == $past(low_req))); // R2

    AST_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n != NONE && hi_req) |=> gnt_n == NONE); // R6

    AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n != NONE && !lock_n && !hi_req) |=> $stable(gnt_n)); // R5

    AST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n != NONE) |=> (gnt_n == $past(gnt_n) || gnt_n == NONE)); // R7

    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n != NONE && lock_n && ((rq & ~gnt_n) == '0)) |=> gnt_n == NONE); // R8
endmodule

bind fixed_prio_arb fixed_prio_arb_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (req_n),
    .lock_n (lock_n),
    .gnt_n  (gnt_n)
);

// File: tb/tb_fixed_prio_arb.sv
module tb_fixed_prio_arb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_n;
    logic       lock_n;
    logic [3:0] gnt_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fixed_prio_arb #(.N_MASTERS(4)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (req_n),
        .lock_n (lock_n),
        .gnt_n  (gnt_n)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Expected next grant (active high) from the requirements.
    function automatic logic [3:0] next_grant(input logic [3:0] g,
                                              input logic [3:0] rq,
                                              input logic lk);
        if (g != 4'b0000) begin
            if ((rq & (g - 4'd1)) != 4'b0000) return 4'b0000; // higher request
            if (!lk && ((rq & g) == 4'b0000)) return 4'b0000; // owner gone
            return g;
        end
        if (!lk && rq != 4'b0000) return rq & (~rq + 4'd1);
        return 4'b0000;
    endfunction

    logic [3:0] m_gnt = 4'b0000;
    // Reference model updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) m_gnt = 4'b0000;
        else        m_gnt = next_grant(m_gnt, ~req_n, ~lock_n);
    end

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: grant actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, then check one rising edge later.
    task automatic step(input logic [3:0] rq, input logic lk,
                        input logic [3:0] exp, input string tag);
        req_n  = ~rq;
        lock_n = ~lk;
        @(negedge clk);
        check(~gnt_n, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'hA5C3));
        rst_n  = 1'b0;
        req_n  = 4'b1010;
        lock_n = 1'b1;
        repeat (3) @(negedge clk);
        check(~gnt_n, 4'b0000, "R1 in reset");

        rst_n = 1'b1;
        req_n = 4'b1111;
        @(negedge clk);
        check(~gnt_n, 4'b0000, "R1 first edge, no request");

        step(4'b0100, 1'b0, 4'b0100, "R2 single request");
        step(4'b0000, 1'b1, 4'b0100, "R5 owner drops under lock");
        step(4'b0001, 1'b1, 4'b0000, "R6 preempt under lock");
        step(4'b0001, 1'b1, 4'b0000, "R4 no grant while locked");
        step(4'b0001, 1'b0, 4'b0001, "R2 grant after lock release");
        step(4'b1001, 1'b0, 4'b0001, "R9 lower request ignored");
        step(4'b1000, 1'b0, 4'b0000, "R8 owner drops, unlocked");
        step(4'b1000, 1'b0, 4'b1000, "R8 remaining request granted");
        step(4'b1010, 1'b0, 4'b0000, "R6 preempt unlocked");
        step(4'b1010, 1'b0, 4'b0010, "R7 gap then new owner");
        step(4'b1110, 1'b0, 4'b0010, "R9 lower requests ignored");
        step(4'b1110, 1'b1, 4'b0010, "R5 hold under lock");
        step(4'b0000, 1'b0, 4'b0000, "R8 owner leaves");
        step(4'b0000, 1'b0, 4'b0000, "R8 none pending");
        step(4'b1111, 1'b0, 4'b0001, "R2 all request, master 0 wins");

        // Reset while a grant is held.
        rst_n = 1'b0;
        @(negedge clk);
        check(~gnt_n, 4'b0000, "R1 reset with owner");
        rst_n = 1'b1;
        step(4'b1100, 1'b0, 4'b0100, "R2 master 2 over 3");

        // Random phase compared with the reference model.
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] rq;
            rq     = 4'($urandom) & 4'($urandom);
            req_n  = ~rq;
            lock_n = ($urandom % 10) >= 3;
            @(negedge clk);
            check(~gnt_n, m_gnt, "R3 random vs model");
            if ($countones(~gnt_n) > 1)
                check(~gnt_n, m_gnt, "R3 more than one grant");
        end
        finish_run();
    end
endmodule